// File: doc/BRIEF.md
# Tap Event Detector

This block watches a stream of signed three-axis acceleration samples and reports short, sharp impacts ("taps"). A sample-valid strobe marks each new sample; every other cycle is ignored by the detection timers. An axis is considered hit when the magnitude of its sample reaches a programmable threshold. Only enabled axes take part, and they are combined with OR. A hit run that ends within a programmable number of samples counts as a tap and raises a one-cycle single-tap pulse.

When double-tap detection is armed, a valid first tap is followed by a quiet period, whose samples are ignored, and then by a window in which a second tap may begin. A valid second tap raises a one-cycle double-tap pulse. The second tap is rejected if the signal is already over threshold on the first window sample, or if it stays over threshold longer than the duration limit. A one-hot status field records which axis was over threshold first in the tap that produced the latest pulse. Detection works on the raw samples presented at the inputs; no filtering takes place inside.

Top module: `tap_detect`

## Requirements
- R1: An enabled axis is hit when the absolute value of its signed sample is greater than or equal to `tap_thr` (so -1000 is a hit and -999 is not for a threshold of 1000). Disabled axes never take part, and the enabled axes are combined with OR.
- R2: A run of N consecutive valid samples with a hit, followed by a valid sample without one, is a valid tap when 1 <= N <= `tap_dur`. When `sgl_en` is 1, `sgl_pulse` is high for exactly one clock, in the cycle after the first non-hit sample.
- R3: A run that reaches `tap_dur` + 1 hit samples gives no pulse. The detector waits for a non-hit sample and only then becomes idle.
- R4: After a valid first tap with double detection armed, `gap_len` valid samples are ignored, including any hits among them. Then `win_len` window samples follow. A tap that starts on window sample 1 .. `win_len`-1 (counting from 0) and is valid under R2 gives a one-cycle `dbl_pulse`, again in the cycle after its first non-hit sample.
- R5: If no hit occurs in the window, the detector becomes idle, and the next hit starts a new first tap.
- R6: A hit on window sample 0 rejects the double tap. No double pulse follows, and the detector goes idle after the next non-hit sample.
- R7: A second tap that reaches `tap_dur` + 1 hit samples gives no double pulse.
- R8: Double detection is armed only when `dbl_en` = 1, `gap_len` != 0 and `win_len` != 0. When it is not armed, each valid tap returns the detector to idle at once, so back-to-back taps each give a single pulse.
- R9: `sgl_en` and `dbl_en` gate their own pulses independently. The single pulse of a first tap is issued whether or not a double tap follows. `axis_en` bit 0/1/2 includes X/Y/Z.
- R10: `first_axis` is one-hot: bit 0 = X, bit 1 = Y, bit 2 = Z. It takes the hit axis from the first sample of the tap whose completion raised a pulse; if several axes are hit on that sample, the lowest index wins. It changes in the same cycle as that pulse and is otherwise never cleared.
- R11: Synchronous active-high `rst` returns the detector to idle with counters at zero. Pulses go low and `first_axis` becomes 000, even in the middle of a tap.
- R12: Only cycles with `smp_vld` = 1 advance detection. Cycles without it do not count toward any limit, and pulses appear only in the cycle after a valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | New sample present on the acceleration inputs |
| acc_x | input | SAMPLE_W | Signed X sample |
| acc_y | input | SAMPLE_W | Signed Y sample |
| acc_z | input | SAMPLE_W | Signed Z sample |
| tap_thr | input | THR_W | Unsigned magnitude threshold |
| tap_dur | input | CNT_W | Maximum tap length in samples |
| gap_len | input | CNT_W | Samples ignored after a first tap |
| win_len | input | CNT_W | Second-tap window length in samples |
| axis_en | input | 3 | Per-axis participation, bit 0 = X |
| sgl_en | input | 1 | Enable single-tap pulses |
| dbl_en | input | 1 | Enable double-tap detection and pulses |
| sgl_pulse | output | 1 | One-cycle single-tap event |
| dbl_pulse | output | 1 | One-cycle double-tap event |
| first_axis | output | 3 | One-hot axis of the latest reported tap |

## Verification
A sequencer stuck in the wrong phase shows up at the ports within one window length. A missing or extra pulse appears one clock after the sample that should have completed a tap. An off-by-one in the duration, gap or window counter moves a tap across a boundary, so the bench places taps exactly at length `tap_dur`, at `tap_dur` + 1, on window sample 0 and on the last window sample, where the pulse either appears or is absent. A wrong captured axis is visible on `first_axis` in the same cycle as the pulse it belongs to.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int AXES = 3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TAP1   = 3'd1,
        ST_GAP    = 3'd2,
        ST_WINDOW = 3'd3,
        ST_TAP2   = 3'd4,
        ST_HOLD   = 3'd5
    } tap_state_e;

    typedef struct packed {
        logic sgl;
        logic dbl;
    } tap_evt_t;

    // Keep only the lowest set bit: lowest axis index wins ties.
    function automatic logic [AXES-1:0] lowest_set(input logic [AXES-1:0] m);
        return m & (~m + 1'b1);
    endfunction

endpackage

// File: rtl/tap_axis_cmp.sv
module tap_axis_cmp #(
    parameter int SAMPLE_W = 16,
    parameter int THR_W    = 16
) (
    input  logic signed [SAMPLE_W-1:0] smp,
    input  logic [THR_W-1:0]           thr,
    input  logic                       en,
    output logic                       hit
);
    localparam int CMP_W = (SAMPLE_W + 1 > THR_W) ? SAMPLE_W + 1 : THR_W;

    logic [SAMPLE_W:0] ext;
    logic [SAMPLE_W:0] mag;
    logic [CMP_W-1:0]  mag_w;
    logic [CMP_W-1:0]  thr_w;

    always_comb begin
        ext   = {smp[SAMPLE_W-1], smp};
        mag   = smp[SAMPLE_W-1] ? (~ext + 1'b1) : ext;
        mag_w = '0;
        mag_w[SAMPLE_W:0] = mag;
        thr_w = '0;
        thr_w[THR_W-1:0] = thr;
        hit   = en && (mag_w >= thr_w);
    end

    always_comb begin
        if (!en) begin
            AST_DISABLED_NO_HIT: assert (hit == 1'b0); // R1
        end
    end

endmodule

// File: rtl/tap_seq_fsm.sv
module tap_seq_fsm
    import tap_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic             hit,
    input  logic [CNT_W-1:0] dur,
    input  logic [CNT_W-1:0] gap,
    input  logic [CNT_W-1:0] win,
    input  logic             dbl_en,
    output tap_evt_t         evt,
    output logic             start
);
    tap_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W:0]   cnt_inc;
    logic             armed;

    always_comb begin
        cnt_inc = {1'b0, cnt} + 1'b1;
        armed   = dbl_en && (gap != '0) && (win != '0);
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        evt     = '0;
        start   = 1'b0;
        if (smp_vld) begin
            unique case (state)
                ST_IDLE: begin
                    if (hit) begin
                        state_n = ST_TAP1;
                        cnt_n   = CNT_W'(1);
                        start   = 1'b1;
                    end
                end
                ST_TAP1, ST_TAP2: begin
                    if (hit) begin
                        if (cnt >= dur) begin
                            state_n = ST_HOLD;
                            cnt_n   = '0;
                        end else begin
                            cnt_n = cnt_inc[CNT_W-1:0];
                        end
                    end else begin
                        cnt_n   = '0;
                        state_n = ST_IDLE;
                        if (cnt <= dur) begin
                            if (state == ST_TAP1) begin
                                evt.sgl = 1'b1;
                                if (armed) state_n = ST_GAP;
                            end else begin
                                evt.dbl = 1'b1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (cnt_inc >= {1'b0, gap}) begin
                        state_n = ST_WINDOW;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_inc[CNT_W-1:0];
                    end
                end
                ST_WINDOW: begin
                    if (hit) begin
                        cnt_n = '0;
                        if (cnt == '0) begin
                            state_n = ST_HOLD;
                        end else begin
                            state_n = ST_TAP2;
                            cnt_n   = CNT_W'(1);
                            start   = 1'b1;
                        end
                    end else if (cnt_inc >= {1'b0, win}) begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_inc[CNT_W-1:0];
                    end
                end
                ST_HOLD: begin
                    if (!hit) begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    AST_WINDOW_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WINDOW) |-> (cnt < win)); // R5

    AST_TAP_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_TAP1) || (state == ST_TAP2)) |-> ((cnt <= dur) || (cnt == CNT_W'(1)))); // R3

    AST_IDLE_CYCLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> ($stable(state) && $stable(cnt))); // R12

    AST_DBL_NEEDS_COUNTS: assert property (@(posedge clk) disable iff (rst)
        evt.dbl |-> ((gap != '0) && (win != '0))); // R8

endmodule

// File: rtl/tap_report.sv
module tap_report
    import tap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_vld,
    input  logic [AXES-1:0] hit_mask,
    input  logic            start,
    input  tap_evt_t        evt,
    input  logic            sgl_en,
    input  logic            dbl_en,
    output logic            sgl_pulse,
    output logic            dbl_pulse,
    output logic [AXES-1:0] first_axis
);
    logic [AXES-1:0] cand;
    logic            sgl_fire, dbl_fire;

    always_comb begin
        sgl_fire = evt.sgl && sgl_en;
        dbl_fire = evt.dbl && dbl_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand       <= '0;
            first_axis <= '0;
            sgl_pulse  <= 1'b0;
            dbl_pulse  <= 1'b0;
        end else begin
            sgl_pulse <= sgl_fire;
            dbl_pulse <= dbl_fire;
            if (start) cand <= lowest_set(hit_mask);
            if (sgl_fire || dbl_fire) first_axis <= cand;
        end
    end

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(first_axis)); // R10

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
        !(sgl_pulse || dbl_pulse) |-> $stable(first_axis)); // R10

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(sgl_pulse && dbl_pulse)); // R2

    AST_PULSE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (sgl_pulse || dbl_pulse) |-> $past(smp_vld)); // R12

    AST_SGL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sgl_pulse |=> !sgl_pulse); // R2

endmodule

// File: rtl/tap_detect.sv
module tap_detect
    import tap_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int THR_W    = 16,
    parameter int CNT_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_vld,
    input  logic signed [SAMPLE_W-1:0] acc_x,
    input  logic signed [SAMPLE_W-1:0] acc_y,
    input  logic signed [SAMPLE_W-1:0] acc_z,
    input  logic [THR_W-1:0]           tap_thr,
    input  logic [CNT_W-1:0]           tap_dur,
    input  logic [CNT_W-1:0]           gap_len,
    input  logic [CNT_W-1:0]           win_len,
    input  logic [2:0]                 axis_en,
    input  logic                       sgl_en,
    input  logic                       dbl_en,
    output logic                       sgl_pulse,
    output logic                       dbl_pulse,
    output logic [2:0]                 first_axis
);
    logic signed [SAMPLE_W-1:0] acc [AXES];
    logic [AXES-1:0]            hit_mask;
    logic                       any_hit;
    logic                       start;
    tap_evt_t                   evt;

    assign acc[0] = acc_x;
    assign acc[1] = acc_y;
    assign acc[2] = acc_z;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        tap_axis_cmp #(
            .SAMPLE_W(SAMPLE_W),
            .THR_W   (THR_W)
        ) i_cmp (
            .smp(acc[a]),
            .thr(tap_thr),
            .en (axis_en[a]),
            .hit(hit_mask[a])
        );
    end

    assign any_hit = |hit_mask;

    tap_seq_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk    (clk),
        .rst    (rst),
        .smp_vld(smp_vld),
        .hit    (any_hit),
        .dur    (tap_dur),
        .gap    (gap_len),
        .win    (win_len),
        .dbl_en (dbl_en),
        .evt    (evt),
        .start  (start)
    );

    tap_report i_report (
        .clk       (clk),
        .rst       (rst),
        .smp_vld   (smp_vld),
        .hit_mask  (hit_mask),
        .start     (start),
        .evt       (evt),
        .sgl_en    (sgl_en),
        .dbl_en    (dbl_en),
        .sgl_pulse (sgl_pulse),
        .dbl_pulse (dbl_pulse),
        .first_axis(first_axis)
    );

    AST_SGL_GATED: assert property (@(posedge clk) disable iff (rst)
        sgl_pulse |-> $past(sgl_en)); // R9

    AST_DBL_GATED: assert property (@(posedge clk) disable iff (rst)
        dbl_pulse |-> $past(dbl_en)); // R9

endmodule

// File: tb/test_tap_detect.sv
module test_tap_detect;

    localparam int SAMPLE_W = 16;
    localparam int THR_W    = 16;
    localparam int CNT_W    = 8;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       smp_vld = 1'b0;
    logic signed [SAMPLE_W-1:0] acc_x = '0, acc_y = '0, acc_z = '0;
    logic [THR_W-1:0]           tap_thr = 16'd1000;
    logic [CNT_W-1:0]           tap_dur = 8'd3;
    logic [CNT_W-1:0]           gap_len = 8'd2;
    logic [CNT_W-1:0]           win_len = 8'd4;
    logic [2:0]                 axis_en = 3'b111;
    logic                       sgl_en = 1'b1;
    logic                       dbl_en = 1'b1;
    logic                       sgl_pulse, dbl_pulse;
    logic [2:0]                 first_axis;

    always #2.5 clk = ~clk;

    tap_detect #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .CNT_W(CNT_W)) i_tap_detect (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
        .tap_thr(tap_thr), .tap_dur(tap_dur), .gap_len(gap_len), .win_len(win_len),
        .axis_en(axis_en), .sgl_en(sgl_en), .dbl_en(dbl_en),
        .sgl_pulse(sgl_pulse), .dbl_pulse(dbl_pulse), .first_axis(first_axis)
    );

    typedef struct {
        bit         dbl;
        logic [2:0] axis;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_evt(input bit dbl, input logic [2:0] axis, input string tag);
        exp_t e;
        e.dbl = dbl; e.axis = axis; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic score(input bit dbl);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R2", dbl ? "unexpected dbl_pulse count" : "unexpected sgl_pulse count", 1, 0);
        end else begin
            e = exp_q.pop_front();
            check(e.dbl == dbl, e.tag, "pulse kind (1=double)", int'(dbl), int'(e.dbl));
            check(e.axis == first_axis, e.tag, "first_axis", int'(first_axis), int'(e.axis));
        end
    endtask

    // Monitor: outputs only move on posedge, so sample on negedge.
    always @(negedge clk) begin
        if (!rst) begin
            if (sgl_pulse) score(1'b0);
            if (dbl_pulse) score(1'b1);
        end
    end

    task automatic smp(input int x, input int y, input int z);
        @(negedge clk);
        acc_x = SAMPLE_W'(x); acc_y = SAMPLE_W'(y); acc_z = SAMPLE_W'(z);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic run(input int x, input int y, input int z, input int n);
        for (int i = 0; i < n; i++) smp(x, y, z);
    endtask

    task automatic drain(input string tag);
        run(0, 0, 0, 10);
        check(exp_q.size() == 0, tag, "missing expected pulses", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual cycles %0d expected below %0d", 150000, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check(sgl_pulse == 0 && dbl_pulse == 0, "R11", "pulses after reset", int'(sgl_pulse | dbl_pulse), 0);
        check(first_axis == 3'b000, "R11", "first_axis after reset", int'(first_axis), 0);

        // R2: single tap on X, length 2
        expect_evt(0, 3'b001, "R2");
        run(1200, 0, 0, 2); run(0, 0, 0, 1);
        drain("R2");

        // R1 / R2: -1000 is a hit, length equal to limit
        expect_evt(0, 3'b010, "R1");
        run(0, -1000, 0, 3); run(0, 0, 0, 1);
        drain("R1");

        // R1: -999 is not a hit
        run(0, -999, 0, 2); run(0, 0, 0, 1);
        drain("R1");

        // R3: run of dur+1 gives nothing, status kept
        run(2000, 0, 0, 4); run(0, 0, 0, 1);
        drain("R3");
        check(first_axis == 3'b010, "R10", "first_axis held", int'(first_axis), 2);

        // R4: double tap on Z, hits in gap ignored
        expect_evt(0, 3'b100, "R4");
        expect_evt(1, 3'b100, "R4");
        run(0, 0, 2000, 1); run(0, 0, 0, 1);
        run(3000, 0, 0, 2);
        run(0, 0, 0, 1);
        run(0, 0, 2000, 1); run(0, 0, 0, 1);
        drain("R4");

        // R6: hit on window sample 0 rejects
        expect_evt(0, 3'b001, "R6");
        run(1500, 0, 0, 1); run(0, 0, 0, 1);
        run(0, 0, 0, 2);
        run(1500, 0, 0, 2); run(0, 0, 0, 1);
        drain("R6");

        // R7: second tap too long
        expect_evt(0, 3'b010, "R7");
        run(0, 1500, 0, 1); run(0, 0, 0, 1);
        run(0, 0, 0, 3);
        run(0, 1500, 0, 4); run(0, 0, 0, 1);
        drain("R7");

        // R4: second tap on last window sample
        expect_evt(0, 3'b001, "R4");
        expect_evt(1, 3'b001, "R4");
        run(1500, 0, 0, 1); run(0, 0, 0, 1);
        run(0, 0, 0, 2); run(0, 0, 0, 3);
        run(1500, 0, 0, 1); run(0, 0, 0, 1);
        drain("R4");

        // R5: window expired, next hit is a new first tap
        expect_evt(0, 3'b001, "R5");
        expect_evt(0, 3'b010, "R5");
        run(1500, 0, 0, 1); run(0, 0, 0, 1);
        run(0, 0, 0, 2); run(0, 0, 0, 4);
        run(0, 1500, 0, 1); run(0, 0, 0, 1);
        drain("R5");

        // R8: zero gap disarms double detection
        gap_len = 8'd0;
        expect_evt(0, 3'b001, "R8");
        expect_evt(0, 3'b001, "R8");
        run(1500, 0, 0, 1); run(0, 0, 0, 1);
        run(1500, 0, 0, 1); run(0, 0, 0, 1);
        drain("R8");
        gap_len = 8'd2;

        // R9: single disabled, double still reported
        sgl_en = 1'b0;
        expect_evt(1, 3'b100, "R9");
        run(0, 0, 1500, 1); run(0, 0, 0, 1);
        run(0, 0, 0, 3);
        run(0, 0, 1500, 1); run(0, 0, 0, 1);
        drain("R9");
        sgl_en = 1'b1;

        // R9: double disabled, back-to-back singles
        dbl_en = 1'b0;
        expect_evt(0, 3'b010, "R9");
        expect_evt(0, 3'b010, "R9");
        run(0, 1500, 0, 1); run(0, 0, 0, 1);
        run(0, 1500, 0, 1); run(0, 0, 0, 1);
        drain("R9");
        dbl_en = 1'b1;

        // R9: disabled X axis ignored
        axis_en = 3'b110;
        run(3000, 0, 0, 1); run(0, 0, 0, 1);
        drain("R9");
        check(first_axis == 3'b010, "R9", "first_axis after disabled axis", int'(first_axis), 2);
        expect_evt(0, 3'b010, "R1");
        run(3000, 1200, 0, 1); run(0, 0, 0, 1);
        drain("R1");
        axis_en = 3'b111;

        // R10: tie goes to lowest index; earliest axis kept
        expect_evt(0, 3'b001, "R10");
        run(1500, 0, 1500, 1); run(0, 0, 0, 1);
        drain("R10");
        expect_evt(0, 3'b010, "R10");
        run(0, 1500, 0, 1); run(1500, 1500, 0, 1); run(0, 0, 0, 1);
        drain("R10");

        // R12: cycles without smp_vld do not count
        expect_evt(0, 3'b001, "R12");
        smp(2000, 0, 0);
        repeat (10) @(negedge clk);
        smp(2000, 0, 0);
        run(0, 0, 0, 1);
        drain("R12");

        // R11: reset in the middle of a tap
        run(2000, 0, 0, 1);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(first_axis == 3'b000, "R11", "first_axis after mid-tap reset", int'(first_axis), 0);
        run(0, 0, 0, 1);
        drain("R11");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule